// File: doc/BRIEF.md
# I2C 10-bit Address Phase Sequencer

This block runs the addressing part of an I2C master transaction whose target has a 10-bit slave address. A caller hands it the 10-bit address and a direction flag. The block then drives a byte-level command interface toward an I2C bit engine. It asks the engine for a START or a repeated START, loads address bytes, and reacts to the acknowledge the engine reports for each byte. When addressing succeeds, it emits a single-cycle ready pulse that carries the final direction, so the data-phase logic knows whether to transmit or receive. If any address byte is not acknowledged, it reports which byte failed and goes back to idle. The STOP condition, bit timing and data bytes are handled elsewhere.

A write sends a START, the high address byte with the write flag, and then the low address byte. A read sends the same three items, then a repeated START, and then only the high address byte again, this time with the read flag. The engine keeps a sticky start-complete flag. The block clears that flag with a one-cycle pulse whenever it uses the flag to continue.

Top module: `i2c10_addr_seq`

## Requirements
- R1: The high address byte is `{5'b11110, addr[9:8], dir}`, with dir = 0 for write and dir = 1 for read. It appears on `tx_byte` while `go_send` is high.
- R2: The low address byte equals `addr[7:0]` and carries no direction flag.
- R3: A write request produces exactly this command order: start, high byte with dir 0, low byte. It then ends with a ready pulse in which `ready_read` = 0.
- R4: A read request produces exactly this command order: start, high byte with dir 0, low byte, start, high byte with dir 1. It then ends with a ready pulse in which `ready_read` = 1. The low byte is not sent a second time.
- R5: A byte is loaded only in the cycle after the engine showed `tx_empty` high, or after a start, `start_flag` high. The bytes that follow a start are never loaded before the start has completed.
- R6: `flag_clr` pulses once each time the block continues on a set `start_flag`, and at no other time.
- R7: A NACK on any address byte makes `err` pulse for one cycle. `err_idx` gives the failing byte: 0 for the high byte of the first pass, 1 for the low byte, 2 for the high byte after the repeated START. No further command is then issued, and the block returns to idle.
- R8: A request that arrives while the block is busy is ignored. The transaction in progress keeps its address and direction.
- R9: `busy` is 0 after reset. It rises in the cycle after a request is accepted and stays high until the cycle in which `ready` or `err` is asserted.
- R10: `ready` is high for exactly one cycle per successful transaction, and `ready` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 10 | 10-bit slave address |
| req_read | input | 1 | 1 = read, 0 = write |
| busy | output | 1 | Address phase in progress |
| go_start | output | 1 | One-cycle command: issue START or repeated START |
| go_send | output | 1 | One-cycle command: load `tx_byte` |
| tx_byte | output | 8 | Address byte to load |
| flag_clr | output | 1 | One-cycle clear of the engine's start-complete flag |
| start_flag | input | 1 | Sticky start-complete flag from the engine |
| tx_empty | input | 1 | Engine transmit buffer empty |
| ack_valid | input | 1 | One-cycle strobe: acknowledge for the last byte |
| ack_nack | input | 1 | With `ack_valid`: 1 = NACK, 0 = ACK |
| ready | output | 1 | One-cycle pulse: address phase done |
| ready_read | output | 1 | Direction for the data phase, valid with `ready` |
| err | output | 1 | One-cycle pulse: address byte not acknowledged |
| err_idx | output | 2 | Index of the failing byte, valid with `err` |

## Verification
The assertions assume the engine behaves in a fixed way. It drops `tx_empty` in the edge at which it accepts a `go_start` or `go_send`. It delivers exactly one `ack_valid` per loaded byte. It raises `start_flag` only as the completion of a start. Under these conditions, the one-cycle lag between a load and the engine state that allowed it is enough to check R5.

The bench models the engine as a counter-driven responder that keeps these rules. It lowers `tx_empty` on each command, restores it a few cycles later, and acknowledges each byte later still. Transactions alternate between completing a start with the flag and completing it with `tx_empty` alone. This exercises both continuation paths of R5 and R6.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int SLV_ADDR_W = 10;
    localparam int HI_BITS    = SLV_ADDR_W - 8;
    localparam logic [4:0] TEN_BIT_MARK = 5'b11110;

    localparam logic [1:0] IDX_HI_W = 2'd0;
    localparam logic [1:0] IDX_LO   = 2'd1;
    localparam logic [1:0] IDX_HI_R = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT_START,
        ST_WAIT_ACK,
        ST_WAIT_EMPTY
    } seq_state_e;

    typedef struct packed {
        seq_state_e            st;
        logic [SLV_ADDR_W-1:0] addr;
        logic                  rd;
        logic [1:0]            idx;
        logic                  busy;
        logic                  go_start;
        logic                  go_send;
        logic                  flag_clr;
        logic                  ready;
        logic                  err;
        logic [1:0]            err_idx;
    } seq_regs_t;

endpackage

// File: rtl/i2c10_addr_fmt.sv
module i2c10_addr_fmt
    import i2c10_pkg::*;
#(
    parameter int         ADDR_W = SLV_ADDR_W,
    parameter logic [4:0] MARK   = TEN_BIT_MARK
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        sel,
    output logic [7:0]        byte_out
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0]      hi_byte_w;
    logic [7:0]      hi_byte_r;
    logic [HI_W-1:0] hi_bits;

    assign hi_bits   = addr[ADDR_W-1:8];
    assign hi_byte_w = {MARK, hi_bits, 1'b0};
    assign hi_byte_r = {MARK, hi_bits, 1'b1};

    always_comb begin
        unique case (sel)
            IDX_LO:   byte_out = addr[7:0];
            IDX_HI_R: byte_out = hi_byte_r;
            default:  byte_out = hi_byte_w;
        endcase
    end

endmodule

// File: rtl/i2c10_addr_ctrl.sv
module i2c10_addr_ctrl
    import i2c10_pkg::*;
#(
    parameter int ADDR_W = SLV_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_read,
    input  logic              start_flag,
    input  logic              tx_empty,
    input  logic              ack_valid,
    input  logic              ack_nack,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        cur_idx,
    output logic              busy,
    output logic              go_start,
    output logic              go_send,
    output logic              flag_clr,
    output logic              ready,
    output logic              ready_read,
    output logic              err,
    output logic [1:0]        err_idx
);
    seq_regs_t r_q, r_d;

    always_comb begin
        r_d          = r_q;
        r_d.go_start = 1'b0;
        r_d.go_send  = 1'b0;
        r_d.flag_clr = 1'b0;
        r_d.ready    = 1'b0;
        r_d.err      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr     = req_addr;
                    r_d.rd       = req_read;
                    r_d.idx      = IDX_HI_W;
                    r_d.busy     = 1'b1;
                    r_d.go_start = 1'b1;
                    r_d.st       = ST_START;
                end
            end
            ST_START: begin
                r_d.st = ST_WAIT_START;
            end
            ST_WAIT_START: begin
                if (start_flag || tx_empty) begin
                    r_d.flag_clr = start_flag;
                    r_d.go_send  = 1'b1;
                    r_d.st       = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_valid) begin
                    if (ack_nack) begin
                        r_d.err     = 1'b1;
                        r_d.err_idx = r_q.idx;
                        r_d.busy    = 1'b0;
                        r_d.st      = ST_IDLE;
                    end else if (r_q.idx == IDX_HI_R) begin
                        r_d.ready = 1'b1;
                        r_d.busy  = 1'b0;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.st = ST_WAIT_EMPTY;
                    end
                end
            end
            ST_WAIT_EMPTY: begin
                if (tx_empty) begin
                    if (r_q.idx == IDX_HI_W) begin
                        r_d.idx     = IDX_LO;
                        r_d.go_send = 1'b1;
                        r_d.st      = ST_WAIT_ACK;
                    end else if (r_q.rd) begin
                        r_d.idx      = IDX_HI_R;
                        r_d.go_start = 1'b1;
                        r_d.st       = ST_START;
                    end else begin
                        r_d.ready = 1'b1;
                        r_d.busy  = 1'b0;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_addr   = r_q.addr;
    assign cur_idx    = r_q.idx;
    assign busy       = r_q.busy;
    assign go_start   = r_q.go_start;
    assign go_send    = r_q.go_send;
    assign flag_clr   = r_q.flag_clr;
    assign ready      = r_q.ready;
    assign ready_read = r_q.rd;
    assign err        = r_q.err;
    assign err_idx    = r_q.err_idx;

    AST_SEND_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        go_send |-> $past(tx_empty || start_flag)); // R5
    AST_CLR_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |-> ($past(start_flag) && go_send)); // R6
    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_start && go_send)); // R3
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R10
    AST_READY_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && err)); // R10
    AST_ERR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_idx != 2'd3)); // R7
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ready || err)); // R9
    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.st != ST_IDLE) |=> $stable(cur_addr)); // R8

endmodule

// File: rtl/i2c10_addr_seq.sv
module i2c10_addr_seq
    import i2c10_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [SLV_ADDR_W-1:0] req_addr,
    input  logic                  req_read,
    output logic                  busy,
    output logic                  go_start,
    output logic                  go_send,
    output logic [7:0]            tx_byte,
    output logic                  flag_clr,
    input  logic                  start_flag,
    input  logic                  tx_empty,
    input  logic                  ack_valid,
    input  logic                  ack_nack,
    output logic                  ready,
    output logic                  ready_read,
    output logic                  err,
    output logic [1:0]            err_idx
);
    logic [SLV_ADDR_W-1:0] cur_addr;
    logic [1:0]            cur_idx;

    i2c10_addr_ctrl #(.ADDR_W(SLV_ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_read   (req_read),
        .start_flag (start_flag),
        .tx_empty   (tx_empty),
        .ack_valid  (ack_valid),
        .ack_nack   (ack_nack),
        .cur_addr   (cur_addr),
        .cur_idx    (cur_idx),
        .busy       (busy),
        .go_start   (go_start),
        .go_send    (go_send),
        .flag_clr   (flag_clr),
        .ready      (ready),
        .ready_read (ready_read),
        .err        (err),
        .err_idx    (err_idx)
    );

    i2c10_addr_fmt #(.ADDR_W(SLV_ADDR_W), .MARK(TEN_BIT_MARK)) u_fmt (
        .addr     (cur_addr),
        .sel      (cur_idx),
        .byte_out (tx_byte)
    );

endmodule

// File: tb/i2c10_addr_seq_tb.sv
module i2c10_addr_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] req_addr = '0;
    logic       req_read = 1'b0;
    logic       busy, go_start, go_send, flag_clr, ready, ready_read, err;
    logic [7:0] tx_byte;
    logic [1:0] err_idx;
    logic       start_flag, tx_empty, ack_valid, ack_nack;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    i2c10_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .busy(busy), .go_start(go_start), .go_send(go_send),
        .tx_byte(tx_byte), .flag_clr(flag_clr), .start_flag(start_flag),
        .tx_empty(tx_empty), .ack_valid(ack_valid), .ack_nack(ack_nack),
        .ready(ready), .ready_read(ready_read), .err(err), .err_idx(err_idx)
    );

    // engine responder
    int nack_at = 3;
    bit flag_mode = 1'b0;
    int scnt, tcnt, acnt, byte_no, flag_sets;

    always @(posedge clk) begin
        if (!rst_n) begin
            start_flag <= 1'b0; tx_empty <= 1'b1; ack_valid <= 1'b0; ack_nack <= 1'b0;
            scnt <= 0; tcnt <= 0; acnt <= 0; byte_no <= 0; flag_sets <= 0;
        end else begin
            ack_valid <= 1'b0;
            if (!busy && acnt == 0) byte_no <= 0;
            if (flag_clr) start_flag <= 1'b0;
            if (go_start) begin
                tx_empty <= 1'b0; scnt <= 3;
            end else if (scnt > 0) begin
                scnt <= scnt - 1;
                if (scnt == 1) begin
                    tx_empty <= 1'b1;
                    if (!flag_mode) begin start_flag <= 1'b1; flag_sets <= flag_sets + 1; end
                end
            end
            if (go_send) begin
                tx_empty <= 1'b0; tcnt <= 2; acnt <= 6;
            end else begin
                if (tcnt > 0) begin tcnt <= tcnt - 1; if (tcnt == 1) tx_empty <= 1'b1; end
                if (acnt > 0) begin
                    acnt <= acnt - 1;
                    if (acnt == 1) begin
                        ack_valid <= 1'b1;
                        ack_nack  <= (byte_no == nack_at);
                        byte_no   <= byte_no + 1;
                    end
                end
            end
        end
    end

    // event monitor
    logic [8:0] evlog [0:7];
    int  evn = 0, clr_n = 0, rdy_n = 0, bad_load = 0;
    bit  prev_ok = 1'b0;
    always @(posedge clk) begin
        #1;
        cycles++;
        if (go_start && evn < 8) begin evlog[evn] = 9'h100; evn++; end
        if (go_send) begin
            if (evn < 8) begin evlog[evn] = {1'b0, tx_byte}; evn++; end
            if (!prev_ok) bad_load++;
        end
        if (flag_clr) clr_n++;
        if (ready) rdy_n++;
        prev_ok = tx_empty || start_flag;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [9:0] a, input bit rd, input int nk,
                           input bit fm, input bit poke);
        logic [8:0] exp_ev [0:7];
        int exp_n, t;
        int f0;
        bit got_r, got_e, got_rr;
        logic [1:0] got_idx;
        nack_at = nk; flag_mode = fm;
        exp_ev[0] = 9'h100;
        exp_ev[1] = {1'b0, 5'b11110, a[9:8], 1'b0};
        exp_ev[2] = {1'b0, a[7:0]};
        exp_ev[3] = 9'h100;
        exp_ev[4] = {1'b0, 5'b11110, a[9:8], 1'b1};
        exp_n = rd ? 5 : 3;
        if (nk == 0) exp_n = 2; else if (nk == 1) exp_n = 3;
        @(negedge clk);
        evn = 0; clr_n = 0; rdy_n = 0; bad_load = 0; f0 = flag_sets;
        req_addr = a; req_read = rd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        t = 0; got_r = 0; got_e = 0; got_rr = 0; got_idx = 0;
        while (!got_r && !got_e && t < 300) begin
            if (poke && t == 4) begin
                req_addr = ~a; req_read = ~rd; req_valid = 1'b1;
            end else req_valid = 1'b0;
            @(negedge clk);
            t++;
            got_r = ready; got_e = err; got_rr = ready_read; got_idx = err_idx;
            if (!got_r && !got_e) chk(busy == 1'b1, "R9 busy held", busy, 1);
        end
        req_valid = 1'b0;
        chk(busy == 1'b0, "R9 busy low at end", busy, 0);
        if (nk <= 2) begin
            chk(got_e && !got_r, "R7 err asserted", got_e, 1);
            chk(got_idx == 2'(nk), "R7 err_idx", got_idx, nk);
        end else begin
            chk(got_r && !got_e, rd ? "R4 ready" : "R3 ready", got_r, 1);
            chk(got_rr == rd, rd ? "R4 ready_read" : "R3 ready_read", got_rr, rd);
        end
        repeat (12) @(negedge clk);
        chk(evn == exp_n, poke ? "R8 event count" : (nk <= 2 ? "R7 event count" : "R3/R4 event count"),
            evn, exp_n);
        for (int i = 0; i < exp_n && i < evn; i++) begin
            chk(evlog[i] == exp_ev[i],
                (i == 2) ? "R2 low byte" : (i == 1 || i == 4) ? "R1 high byte" : "R4 start order",
                evlog[i], exp_ev[i]);
        end
        chk(clr_n == flag_sets - f0, "R6 clear count", clr_n, flag_sets - f0);
        chk(bad_load == 0, "R5 load gated", bad_load, 0);
        chk(rdy_n == ((nk <= 2) ? 0 : 1), "R10 ready width", rdy_n, (nk <= 2) ? 0 : 1);
        chk(ready == 1'b0 && err == 1'b0 && busy == 1'b0, "R7 idle after end", {ready, err, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && ready == 0 && err == 0 && go_start == 0 && go_send == 0 && flag_clr == 0,
            "R9 reset state", {busy, ready, err, go_start, go_send, flag_clr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 1024; a++) begin
            for (int rd = 0; rd < 2; rd++) begin
                run_txn(10'(a), rd[0], 3, a[0] ^ rd[0], (a % 7) == 0);
            end
        end
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 8; j++) begin
                run_txn(10'(j * 131 + k * 17), 1'b1, k, j[0], 1'b0);
                if (k < 2) run_txn(10'(j * 97 + 5), 1'b0, k, j[1], 1'b0);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule